// File: doc/BRIEF.md
# Streaming Matrix-Vector Multiply Coprocessor

This block sits between a stream source and a stream sink and computes the product of a fixed 64x8 matrix of unsigned bytes with an 8-entry column vector of unsigned bytes. One input frame carries the whole matrix first, one row after another, followed by the vector. The block stores both operands and then works through the matrix row by row. For each row it multiplies the eight matrix bytes by the vector bytes and adds up the products. It shifts each row total right by eight bits and sends the scaled results out in row order, one result per 32-bit word.

Each product gets two clock cycles. The multiplier operands stay fixed for the whole pair, and the accumulator captures on the second cycle only. Both stream ports follow the usual valid/ready rules and tolerate gaps on either side. The output frame ends with an end-of-packet flag on its 64th word. When that word has been taken, the block goes back to accepting the next input frame.

Top module: `matvec_stream`

## Requirements
- R1: While reset is asserted and on the first cycle after it, s_tready_o is 1, and m_tvalid_o and m_tlast_o are 0.
- R2: An input word is taken only on a rising edge where s_tvalid_i and s_tready_o are both 1. Only bits [7:0] carry the operand, and bits [31:8] are ignored. Word k for k < 512 is matrix element row k/8, column k%8. Words 512 to 519 are vector elements 0 to 7.
- R3: s_tready_o stays 1 until the 520th word of a frame has been taken. It then stays 0 until the last result of that frame has been accepted. m_tvalid_o is never 1 while s_tready_o is 1.
- R4: Result i equals floor(sum over j of A[i][j]*B[j] / 256). It is placed in bits [10:0] of m_tdata_o with bits [31:11] zero, and results leave in row order 0 to 63.
- R5: m_tlast_o is 1 only while m_tvalid_o is 1, and only on the 64th result word of a frame. That word always carries it.
- R6: While m_tvalid_o is 1 and m_tready_i is 0, m_tvalid_o, m_tdata_o and m_tlast_o hold their values into the next cycle.
- R7: Gaps in s_tvalid_i and in m_tready_i lose no word and repeat no word.
- R8: On the edge that hands over the 64th result, the block returns to its receive state. On the next cycle s_tready_o is 1 and m_tvalid_o is 0. The next frame's results do not depend on earlier frames.
- R9: The multiplier operands stay stable across both cycles of each product. The first result of a frame becomes valid exactly 16 rising edges after the edge that takes the 520th input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s_tdata_i | input | 32 | Input stream data, operand in bits [7:0] |
| s_tvalid_i | input | 1 | Input stream valid |
| s_tready_o | output | 1 | Input stream ready |
| m_tdata_o | output | 32 | Output stream data, scaled row result |
| m_tvalid_o | output | 1 | Output stream valid |
| m_tready_i | input | 1 | Output stream ready |
| m_tlast_o | output | 1 | End of output frame, on the 64th result |

## Verification
The first frame sets every operand to 255. This gives the largest row total and shows whether the accumulator and the result field are wide enough. The second frame uses random bytes with random garbage in the upper data bits. It inserts input gaps and output stalls, and it drives valid-high garbage while input ready is low. This separates a design that takes words only on a real handshake from one that counts extra words or drops some. The third frame uses a deterministic pattern with zeros and extremes in the vector. It runs right after another frame, so it shows whether accumulators and counters are cleared between frames. Each frame also checks the two-cycle latency per product, the position of the end-of-packet flag, and that data holds through stalls.

// File: rtl/matvec_pkg.sv
package matvec_pkg;
  typedef enum logic [1:0] {
    ST_RECV  = 2'd0,
    ST_CALC  = 2'd1,
    ST_DRAIN = 2'd2
  } mv_state_e;
endpackage

// File: rtl/matvec_operand_store.sv
module matvec_operand_store #(
  parameter int ROWS = 64,
  parameter int COLS = 8,
  parameter int EL_W = 8,
  localparam int A_N    = ROWS * COLS,
  localparam int TOTAL  = A_N + COLS,
  localparam int CNT_W  = $clog2(TOTAL),
  localparam int AIDX_W = $clog2(A_N),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [EL_W-1:0]  wr_data_i,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic [EL_W-1:0]  a_el_o,
  output logic [EL_W-1:0]  b_el_o,
  output logic             frame_full_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [EL_W-1:0]  a_mem [A_N];
  logic [EL_W-1:0]  b_q   [COLS];
  logic             in_a;
  logic [COL_W-1:0] b_idx;
  logic [AIDX_W-1:0] a_rd_idx;

  assign in_a         = cnt_q < CNT_W'(A_N);
  assign b_idx        = COL_W'(cnt_q - CNT_W'(A_N));
  assign frame_full_o = wr_en_i && (cnt_q == CNT_W'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (frame_full_o) cnt_q <= '0;
    else if (wr_en_i)      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && in_a) a_mem[AIDX_W'(cnt_q)] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < COLS; j++) b_q[j] <= '0;
    end else if (wr_en_i && !in_a) begin
      b_q[b_idx] <= wr_data_i;
    end
  end

  assign a_rd_idx = AIDX_W'(rd_row_i) * AIDX_W'(COLS) + AIDX_W'(rd_col_i);
  assign a_el_o   = a_mem[a_rd_idx];
  assign b_el_o   = b_q[rd_col_i];
endmodule

// File: rtl/matvec_row_mac.sv
module matvec_row_mac #(
  parameter int COLS = 8,
  parameter int EL_W = 8,
  localparam int COL_W = $clog2(COLS),
  localparam int ACC_W = 2 * EL_W + $clog2(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [EL_W-1:0]  a_el_i,
  input  logic [EL_W-1:0]  b_el_i,
  output logic [COL_W-1:0] col_o,
  output logic             phase_o,
  output logic             row_done_o,
  output logic [ACC_W-1:0] row_sum_o
);
  logic [COL_W-1:0]  col_q;
  logic              phase_q;
  logic [ACC_W-1:0]  acc_q;
  logic [2*EL_W-1:0] prod;
  logic              last_col;

  // operands come from col_q, which only moves after the capture cycle
  assign prod       = a_el_i * b_el_i;
  assign last_col   = col_q == COL_W'(COLS - 1);
  assign row_done_o = run_i && phase_q && last_col;
  assign row_sum_o  = acc_q + ACC_W'(prod);
  assign col_o      = col_q;
  assign phase_o    = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q   <= '0;
      phase_q <= 1'b0;
      acc_q   <= '0;
    end else if (run_i) begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (last_col) begin
          col_q <= '0;
          acc_q <= '0;
        end else begin
          col_q <= col_q + 1'b1;
          acc_q <= row_sum_o;
        end
      end
    end
  end
endmodule

// File: rtl/matvec_result_tx.sv
module matvec_result_tx #(
  parameter int DATA_W = 32,
  parameter int RES_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              last_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (load_i) begin
      data_o  <= DATA_W'(res_i);
      valid_o <= 1'b1;
      last_o  <= last_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/matvec_stream.sv
module matvec_stream
  import matvec_pkg::*;
#(
  parameter int ROWS   = 64,
  parameter int COLS   = 8,
  parameter int EL_W   = 8,
  parameter int DATA_W = 32,
  parameter int SHIFT  = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int ACC_W = 2 * EL_W + $clog2(COLS),
  localparam int RES_W = ACC_W - SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic              m_tlast_o
);
  mv_state_e        state_q;
  logic [ROW_W-1:0] row_q;
  logic             in_fire, frame_full, run, row_done, last_row, mac_phase;
  logic [COL_W-1:0] col;
  logic [EL_W-1:0]  a_el, b_el;
  logic [ACC_W-1:0] row_sum;
  logic             unused_bits;

  assign unused_bits = ^{s_tdata_i[DATA_W-1:EL_W], row_sum[SHIFT-1:0]};
  assign s_tready_o  = state_q == ST_RECV;
  assign in_fire     = s_tvalid_i && s_tready_o;
  // hold the engine while a result waits at the output
  assign run         = (state_q == ST_CALC) && !m_tvalid_o;
  assign last_row    = row_q == ROW_W'(ROWS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RECV;
      row_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RECV: if (frame_full) begin
          state_q <= ST_CALC;
          row_q   <= '0;
        end
        ST_CALC: if (row_done) begin
          if (last_row) state_q <= ST_DRAIN;
          else          row_q   <= row_q + 1'b1;
        end
        ST_DRAIN: if (m_tvalid_o && m_tready_i && m_tlast_o) begin
          state_q <= ST_RECV;
          row_q   <= '0;
        end
        default: state_q <= ST_RECV;
      endcase
    end
  end

  matvec_operand_store #(.ROWS(ROWS), .COLS(COLS), .EL_W(EL_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (in_fire),
    .wr_data_i   (s_tdata_i[EL_W-1:0]),
    .rd_row_i    (row_q),
    .rd_col_i    (col),
    .a_el_o      (a_el),
    .b_el_o      (b_el),
    .frame_full_o(frame_full)
  );

  matvec_row_mac #(.COLS(COLS), .EL_W(EL_W)) u_mac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .a_el_i    (a_el),
    .b_el_i    (b_el),
    .col_o     (col),
    .phase_o   (mac_phase),
    .row_done_o(row_done),
    .row_sum_o (row_sum)
  );

  matvec_result_tx #(.DATA_W(DATA_W), .RES_W(RES_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (row_done),
    .res_i  (row_sum[ACC_W-1:SHIFT]),
    .last_i (last_row),
    .ready_i(m_tready_i),
    .data_o (m_tdata_o),
    .valid_o(m_tvalid_o),
    .last_o (m_tlast_o)
  );
endmodule

// File: rtl/matvec_checker.sv
module matvec_checker #(
  parameter int ROWS   = 64,
  parameter int COLS   = 8,
  parameter int EL_W   = 8,
  parameter int DATA_W = 32,
  parameter int SHIFT  = 8,
  localparam int TOTAL = ROWS * COLS + COLS,
  localparam int IC_W  = $clog2(TOTAL + 1),
  localparam int OC_W  = $clog2(ROWS),
  localparam int RES_W = 2 * EL_W + $clog2(COLS) - SHIFT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_tvalid_i,
  input logic              s_tready_i,
  input logic [DATA_W-1:0] m_tdata_i,
  input logic              m_tvalid_i,
  input logic              m_tready_i,
  input logic              m_tlast_i,
  input logic              mac_phase_i,
  input logic [EL_W-1:0]   a_el_i,
  input logic [EL_W-1:0]   b_el_i
);
  logic [IC_W-1:0] in_cnt_q;
  logic [OC_W-1:0] out_cnt_q;
  logic            end_fire;

  assign end_fire = m_tvalid_i && m_tready_i && m_tlast_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
    end else begin
      if (end_fire) begin
        in_cnt_q  <= '0;
        out_cnt_q <= '0;
      end else begin
        if (s_tvalid_i && s_tready_i) in_cnt_q  <= in_cnt_q + 1'b1;
        if (m_tvalid_i && m_tready_i) out_cnt_q <= out_cnt_q + 1'b1;
      end
    end
  end

  assert_ready_until_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cnt_q < IC_W'(TOTAL)) |-> s_tready_i);
  assert_ready_low_when_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cnt_q == IC_W'(TOTAL)) |-> !s_tready_i);
  assert_no_out_in_recv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_tready_i |-> !m_tvalid_i);
  assert_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_i |-> (m_tdata_i[DATA_W-1:RES_W] == '0));
  assert_last_with_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tlast_i |-> m_tvalid_i);
  assert_last_on_final_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_i && out_cnt_q == OC_W'(ROWS - 1)) |-> m_tlast_i);
  assert_no_early_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tlast_i |-> (out_cnt_q == OC_W'(ROWS - 1)));
  assert_hold_on_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_i && !m_tready_i) |=> (m_tvalid_i && $stable(m_tdata_i) && $stable(m_tlast_i)));
  assert_operands_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_phase_i |-> ($stable(a_el_i) && $stable(b_el_i)));
endmodule

bind matvec_stream matvec_checker #(
  .ROWS(ROWS), .COLS(COLS), .EL_W(EL_W), .DATA_W(DATA_W), .SHIFT(SHIFT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s_tvalid_i (s_tvalid_i),
  .s_tready_i (s_tready_o),
  .m_tdata_i  (m_tdata_o),
  .m_tvalid_i (m_tvalid_o),
  .m_tready_i (m_tready_i),
  .m_tlast_i  (m_tlast_o),
  .mac_phase_i(mac_phase),
  .a_el_i     (a_el),
  .b_el_i     (b_el)
);

// File: tb/matvec_stream_tb.sv
module matvec_stream_tb;
  localparam int ROWS = 64;
  localparam int COLS = 8;
  localparam int AN   = ROWS * COLS;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic [31:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b0;
  logic        m_tlast;

  int checks = 0;
  int failures = 0;
  int a_m [AN];
  int b_v [COLS];
  int exp_r [ROWS];

  always #2 clk = ~clk;

  matvec_stream u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_tdata_i(s_tdata), .s_tvalid_i(s_tvalid), .s_tready_o(s_tready),
    .m_tdata_o(m_tdata), .m_tvalid_o(m_tvalid), .m_tready_i(m_tready),
    .m_tlast_o(m_tlast)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic fill(input int kind);
    for (int k = 0; k < AN; k++)
      case (kind)
        0:       a_m[k] = 255;
        1:       a_m[k] = int'($urandom() % 256);
        default: a_m[k] = ((k / COLS) * 7 + (k % COLS) * 13) % 256;
      endcase
    for (int j = 0; j < COLS; j++)
      case (kind)
        0:       b_v[j] = 255;
        1:       b_v[j] = int'($urandom() % 256);
        default: b_v[j] = (j % 3 == 0) ? 0 : ((j % 3 == 1) ? 255 : j * 37);
      endcase
    for (int r = 0; r < ROWS; r++) begin
      int s = 0;
      for (int j = 0; j < COLS; j++) s += a_m[r * COLS + j] * b_v[j];
      exp_r[r] = s >> 8;
    end
  endtask

  // R2 R7: garbage upper bits, optional valid gaps with junk data
  task automatic send_frame(input bit gaps);
    int n;
    @(negedge clk);
    check(s_tready == 1'b1, "R3 ready at frame start", int'(s_tready), 1);
    for (int k = 0; k < AN + COLS; k++) begin
      int v;
      v = (k < AN) ? a_m[k] : b_v[k - AN];
      forever begin
        @(negedge clk);
        if (gaps && ($urandom() % 3 == 0)) begin
          s_tvalid = 1'b0;
          s_tdata  = $urandom();
        end else begin
          s_tvalid = 1'b1;
          s_tdata  = {24'($urandom()), 8'(v)};
          if (s_tready) break;
        end
      end
    end
    @(posedge clk);
    #1 s_tvalid = 1'b0;
    check(s_tready == 1'b0, "R3 ready low after 520 words", int'(s_tready), 0);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      #1;
    end while (!m_tvalid && n < 100);
    check(n == 2 * COLS, "R9 first result latency", n, 2 * COLS);
  endtask

  task automatic collect(input bit stall, input bit junk);
    int idx = 0;
    bit was_stalled = 1'b0;
    logic [31:0] held_d;
    logic held_l;
    while (idx < ROWS) begin
      bit r;
      @(negedge clk);
      if (junk) begin
        s_tvalid = 1'b1;
        s_tdata  = $urandom();
      end
      if (was_stalled) begin
        check(m_tvalid && m_tdata == held_d && m_tlast == held_l,
              "R6 hold during stall", int'(m_tdata), int'(held_d));
      end
      check(s_tready == 1'b0, "R3 ready low during output", int'(s_tready), 0);
      r = stall ? 1'($urandom() % 2) : 1'b1;
      m_tready = r;
      was_stalled = 1'b0;
      if (m_tvalid) begin
        if (r) begin
          check(m_tdata == 32'(exp_r[idx]), $sformatf("R4 R7 result row %0d", idx),
                int'(m_tdata), exp_r[idx]);
          check(m_tlast == (idx == ROWS - 1), $sformatf("R5 last flag row %0d", idx),
                int'(m_tlast), int'(idx == ROWS - 1));
          idx++;
        end else begin
          was_stalled = 1'b1;
          held_d = m_tdata;
          held_l = m_tlast;
        end
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    m_tready = 1'b0;
    check(s_tready == 1'b1, "R8 ready back after frame", int'(s_tready), 1);
    check(m_tvalid == 1'b0, "R8 no output after frame", int'(m_tvalid), 0);
  endtask

  task automatic test_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(s_tready == 1'b1, "R1 ready in reset", int'(s_tready), 1);
    check(m_tvalid == 1'b0, "R1 valid in reset", int'(m_tvalid), 0);
    check(m_tlast == 1'b0, "R1 last in reset", int'(m_tlast), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(s_tready == 1'b1 && !m_tvalid && !m_tlast, "R1 state after reset",
          int'({s_tready, m_tvalid, m_tlast}), 4);
  endtask

  task automatic test_max_frame;
    fill(0);
    send_frame(1'b0);
    collect(1'b0, 1'b0);
  endtask

  task automatic test_random_gaps;
    fill(1);
    send_frame(1'b1);
    collect(1'b1, 1'b1);
  endtask

  task automatic test_pattern_back_to_back;
    fill(2);
    send_frame(1'b1);
    collect(1'b1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_max_frame();
    test_random_gaps();
    test_pattern_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule